// File: doc/BRIEF.md
# Bit-Serial Rank Order Selector

This block picks one value out of a window of N unsigned M-bit samples: the value whose position, counted from the largest, equals a requested rank. It does not sort. It works through the bit columns of the window from the most significant bit down and settles one result bit per clock, so each result takes M cycles. Every sample has a small cell of its own. A ones counter looks at the current column, and a threshold test compares that count with the rank to choose the result bit. Each cell whose bit disagrees with the chosen bit then locks the rest of its bits to that disagreeing value, so the cell keeps its order relative to the result.

A caller places the window on `window_i` and raises `start_i` for one cycle while the block is idle. The window, the rank and the mode are latched on that edge. `done_o` pulses once when the last bit is settled, and `result_o` holds the value until the next accepted start. The mode input makes the same hardware act as a maximum, minimum, median or general rank filter.

Top module: `rank_select_serial`

## Requirements
- R1: While reset is held and right after it, `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: A `start_i` seen at a rising edge while `busy_o` is 0 sets `busy_o` after that edge. `done_o` is 1 for exactly one cycle, after the M-th rising edge that follows the start edge, and `busy_o` falls on that same edge.
- R3: With mode 0 (general rank) and a rank k in 1..N, the result is the k-th largest sample, where rank 1 is the largest. Equal samples each take a rank of their own. Sample i sits in `window_i[i*M +: M]`.
- R4: With mode 1 (maximum), the result is the largest sample, whatever the rank input is.
- R5: With mode 2 (minimum), the result is the smallest sample, whatever the rank input is.
- R6: With mode 3 (median), the result is the sample of rank (N+1)/2 (integer division), whatever the rank input is.
- R7: In mode 0, a rank of 0 acts as rank 1 and a rank above N acts as rank N.
- R8: After `done_o`, `result_o` keeps its value until the next accepted start. `done_o` is 0 in every other cycle.
- R9: A `start_i` that arrives while `busy_o` is 1 is ignored. It changes neither the result nor the time at which `done_o` pulses.
- R10: Changes on `window_i`, `rank_i` and `mode_i` after the start edge do not affect the result being computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a selection when the block is idle |
| mode_i | input | 2 | 0 general rank, 1 maximum, 2 minimum, 3 median |
| rank_i | input | clog2(N+1) | Requested rank; 1 is the largest sample |
| window_i | input | N*M | Window samples; sample i at bits [i*M +: M] |
| busy_o | output | 1 | A selection is in progress |
| done_o | output | 1 | One-cycle pulse when the result is complete |
| result_o | output | M | Selected sample, valid from done_o on |

## Verification
The assertions check on every cycle that the sequencing holds: a last step is followed by one done pulse, a start that is taken leads to busy, and the result is stable while the block is idle. They also check that a cell, once locked, keeps its locked value, that the stored rank stays in 1..N, and that the maximum and minimum result bits agree with the ones count kept by the separate counter. Whether the whole M-bit result is the correct order statistic can only be shown by the bench. It sweeps many windows, including windows with equal samples, across all ranks and all modes, and it also covers inputs that change during a run and starts raised while the block is busy.

// File: rtl/rank_sel_pkg.sv
package rank_sel_pkg;

  typedef enum logic [1:0] {
    SEL_RANK   = 2'd0,
    SEL_MAX    = 2'd1,
    SEL_MIN    = 2'd2,
    SEL_MEDIAN = 2'd3
  } sel_mode_e;

  // Rank actually used for a run: mode overrides, then clamp to 1..n.
  function automatic int unsigned effective_rank(sel_mode_e m, int unsigned r, int unsigned n);
    case (m)
      SEL_MAX:    return 1;
      SEL_MIN:    return n;
      SEL_MEDIAN: return (n + 1) / 2;
      default: begin
        if (r < 1) return 1;
        if (r > n) return n;
        return r;
      end
    endcase
  endfunction

  // Result bit for a column under general rank: set when enough ones.
  function automatic logic rank_bit(int unsigned ones, int unsigned k);
    return (ones >= k);
  endfunction

endpackage

// File: rtl/rof_bit_cell.sv
module rof_bit_cell #(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [M-1:0] sample_i,
  input  logic         dec_i,
  output logic         bit_o
);

  logic [M-1:0] sh_q;
  logic         frc_q;
  logic         fval_q;
  logic         mismatch;

  assign bit_o    = frc_q ? fval_q : sh_q[M-1];
  assign mismatch = step_i && !frc_q && (bit_o != dec_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      frc_q  <= 1'b0;
      fval_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= sample_i;
      frc_q  <= 1'b0;
      fval_q <= 1'b0;
    end else if (step_i) begin
      sh_q <= sh_q << 1;
      if (mismatch) begin
        frc_q  <= 1'b1;
        fval_q <= bit_o;
      end
    end
  end

  // R3
  lock_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !load_i) |=> (frc_q && (bit_o == $past(bit_o))));

  // R3
  lock_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_q && !load_i) |=> (frc_q && $stable(fval_q)));

endmodule

// File: rtl/rof_popcount.sv
module rof_popcount #(
  parameter int N  = 5,
  parameter int CW = 3
) (
  input  logic [N-1:0]  col_i,
  output logic [CW-1:0] ones_o
);

  always_comb begin
    ones_o = '0;
    for (int i = 0; i < N; i++) begin
      ones_o = ones_o + CW'(col_i[i]);
    end
  end

endmodule

// File: rtl/rof_decide.sv
module rof_decide
  import rank_sel_pkg::*;
#(
  parameter int N  = 5,
  parameter int CW = 3
) (
  input  sel_mode_e     mode_i,
  input  logic [N-1:0]  col_i,
  input  logic [CW-1:0] ones_i,
  input  logic [CW-1:0] rank_i,
  output logic          bit_o
);

  always_comb begin
    case (mode_i)
      SEL_MAX: bit_o = |col_i;
      SEL_MIN: bit_o = &col_i;
      default: bit_o = rank_bit(int'(ones_i), int'(rank_i));
    endcase
  end

endmodule

// File: rtl/rof_ctrl.sv
module rof_ctrl #(
  parameter int M = 8,
  localparam int SW = (M > 1) ? $clog2(M) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic busy_o,
  output logic done_o
);

  logic [SW-1:0] cnt_q;
  logic          last;

  assign load_o = start_i && !busy_o;
  assign last   = busy_o && (cnt_q == SW'(M - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end else if (last) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  load_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (busy_o && !done_o));

  // R2
  last_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (done_o && !busy_o));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last && start_i) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/rank_select_serial.sv
module rank_select_serial
  import rank_sel_pkg::*;
#(
  parameter int N = 5,
  parameter int M = 8,
  localparam int KW = $clog2(N + 1),
  localparam int CW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     mode_i,
  input  logic [KW-1:0]  rank_i,
  input  logic [N*M-1:0] window_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [M-1:0]   result_o
);

  logic          load;
  logic [N-1:0]  col;
  logic [CW-1:0] ones;
  logic          dec_bit;
  sel_mode_e     mode_q;
  logic [CW-1:0] rank_q;
  logic [M-1:0]  result_q;

  rof_ctrl #(.M(M)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  for (genvar g = 0; g < N; g++) begin : g_cell
    rof_bit_cell #(.M(M)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .step_i   (busy_o),
      .sample_i (window_i[g*M +: M]),
      .dec_i    (dec_bit),
      .bit_o    (col[g])
    );
  end

  rof_popcount #(.N(N), .CW(CW)) u_count (
    .col_i  (col),
    .ones_o (ones)
  );

  rof_decide #(.N(N), .CW(CW)) u_decide (
    .mode_i (mode_q),
    .col_i  (col),
    .ones_i (ones),
    .rank_i (rank_q),
    .bit_o  (dec_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= SEL_RANK;
      rank_q   <= CW'(1);
      result_q <= '0;
    end else if (load) begin
      mode_q   <= sel_mode_e'(mode_i);
      rank_q   <= CW'(effective_rank(sel_mode_e'(mode_i), int'(rank_i), N));
      result_q <= '0;
    end else if (busy_o) begin
      result_q <= {result_q[M-2:0], dec_bit};
    end
  end

  assign result_o = result_q;

  // R4
  max_zero_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q == SEL_MAX && !dec_bit) |-> (ones == '0));

  // R5
  min_full_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q == SEL_MIN && dec_bit) |-> (ones == CW'(N)));

  // R7
  rank_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rank_q != '0) && (rank_q <= CW'(N)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !load) |=> $stable(result_q));

endmodule

// File: tb/rank_select_serial_test.sv
module rank_select_serial_test;

  localparam int N  = 5;
  localparam int M  = 4;
  localparam int KW = $clog2(N + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start_i;
  logic [1:0]     mode_i;
  logic [KW-1:0]  rank_i;
  logic [N*M-1:0] window_i;
  logic           busy_o;
  logic           done_o;
  logic [M-1:0]   result_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  rank_select_serial #(.N(N), .M(M)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .rank_i   (rank_i),
    .window_i (window_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // k-th largest by counting: v qualifies when fewer than k are above it
  // and at least k are at or above it.
  function automatic int expect_val(logic [N*M-1:0] w, int mode, int rank);
    int k;
    case (mode)
      1: k = 1;
      2: k = N;
      3: k = (N + 1) / 2;
      default: k = (rank < 1) ? 1 : ((rank > N) ? N : rank);
    endcase
    for (int i = 0; i < N; i++) begin
      int gt = 0;
      int ge = 0;
      for (int j = 0; j < N; j++) begin
        if (w[j*M +: M] >  w[i*M +: M]) gt++;
        if (w[j*M +: M] >= w[i*M +: M]) ge++;
      end
      if (gt < k && ge >= k) return int'(w[i*M +: M]);
    end
    return -1;
  endfunction

  function automatic string req_of(int mode, int rank);
    case (mode)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return (rank >= 1 && rank <= N) ? "R3" : "R7";
    endcase
  endfunction

  task automatic run(input logic [N*M-1:0] w, input int mode, input int rank, input bit poke);
    int exp;
    logic [M-1:0] held;
    exp = expect_val(w, mode, rank);
    @(negedge clk);
    window_i = w;
    mode_i   = 2'(mode);
    rank_i   = KW'(rank);
    start_i  = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1 && done_o == 1'b0, "R2", int'(busy_o), 1);
    // R10: disturb the inputs during the run
    window_i = ~w;
    rank_i   = KW'(rank + 1);
    mode_i   = 2'(mode + 1);
    // R9: start while busy
    start_i = poke;
    for (int i = 1; i < M; i++) begin
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(done_o == 1'b0, poke ? "R9" : "R2", int'(done_o), 0);
    @(negedge clk);
    chk(done_o == 1'b1 && busy_o == 1'b0, poke ? "R9" : "R2", int'(done_o), 1);
    chk(int'(result_o) == exp, poke ? "R9" : req_of(mode, rank), int'(result_o), exp);
    held = result_o;
    @(negedge clk);
    chk(done_o == 1'b0 && result_o == held, "R8", int'(result_o), int'(held));
    @(negedge clk);
    chk(result_o == held, "R8", int'(result_o), int'(held));
  endtask

  function automatic logic [N*M-1:0] pack5(int a, int b, int c, int d, int e);
    logic [N*M-1:0] w;
    w = '0;
    w[0*M +: M] = M'(a);
    w[1*M +: M] = M'(b);
    w[2*M +: M] = M'(c);
    w[3*M +: M] = M'(d);
    w[4*M +: M] = M'(e);
    return w;
  endfunction

  task automatic sweep(input logic [N*M-1:0] w);
    for (int r = 0; r < (1 << KW); r++) run(w, 0, r, 1'b0);
    for (int m = 1; m < 4; m++) run(w, m, (m * 3) % (1 << KW), 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    mode_i = 2'd0;
    rank_i = '0;
    window_i = '0;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0 && result_o == '0, "R1", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0 && result_o == '0, "R1", int'(busy_o), 0);

    sweep('0);
    sweep('1);
    sweep(pack5(7, 7, 7, 7, 7));
    sweep(pack5(3, 3, 9, 9, 1));
    sweep(pack5(15, 0, 8, 7, 8));
    sweep(pack5(1, 2, 3, 4, 5));
    sweep(pack5(0, 15, 0, 15, 0));

    run(pack5(12, 4, 9, 2, 6), 0, 2, 1'b1);
    run(pack5(5, 5, 1, 14, 3), 3, 0, 1'b1);

    for (int t = 0; t < 150; t++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sweep(lfsr[N*M-1:0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule